// File: doc/BRIEF.md
# Small-Core Interrupt Control Unit

This unit gathers four interrupt sources for a small processor core: a timer overflow, an external pin, a change detector on three port pins, and a converter-complete peripheral. Each source arrives as a single-cycle event pulse. The pulse sets a sticky flag whatever the enables hold. A flag raises a request only when its own enable is set. The converter source also needs a peripheral-group enable, and every source needs the global enable. Flags are cleared only by software writes.

The gated request goes through a two-stage synchronizer. A small state machine then acts on it, but only at instruction boundaries. Taking an interrupt clears the global enable and pulses a vector-load strobe that carries the fixed vector address. A return strobe sets the global enable again. While the core sleeps, a wake-up output follows every enabled pending source, whatever the global enable holds.

The state machine has three states. S_RUN is normal execution. S_VEC is the one-cycle vector-load state. S_ISR is the state inside the service routine. There are four transitions:
- S_RUN → S_VEC on a take.
- S_VEC → S_ISR always.
- S_ISR → S_RUN on the return strobe.
- S_ISR → S_VEC on a take, for nesting after software sets the global enable.

A take happens at an instruction boundary when the synchronized request is high and the global enable is set.

Top module: `irq_ctl_unit`

## Requirements
- R1: After reset, all three registers read 0x00 and `irq_req`, `vec_load` and `wake` are low.
- R2: An event pulse sets its flag at the next clock edge, whatever any enable holds. The flag bits are ctl bit 2 (timer), bit 1 (external), bit 0 (port change), and pflag bit 6 (converter).
- R3: When an event and a software write reach the same flag in the same cycle, the flag ends up set. Other flags take the written value.
- R4: While ctl bit 7 (global enable) is 0, `vec_load` never asserts.
- R5: The converter source requests only when ctl bit 6 (group enable) and pen bit 6 are both 1. The timer, external and port sources need ctl bits 5, 4 and 3 respectively.
- R6: A take pulses `vec_load` high for exactly one cycle, with `vec_pc` = 0x0004. ctl bit 7 reads 0 in that same cycle.
- R7: With global enable and source enable set, `vec_load` rises after the first clock edge k ≥ N+3 at which `inst_end` is high, where N is the edge that captured the event. With a boundary every cycle, the latency is 3 edges. With a boundary every other cycle, it is 3 or 4 edges.
- R8: `retfie` sets ctl bit 7. If an enabled flag is still set, `vec_load` rises again 3 edges after the return edge. If the flag was cleared first, no re-entry occurs.
- R9: While `sleeping` is high, `wake` is high whenever an enabled source flag is set (including the group enable for the converter), even with ctl bit 7 at 0. `wake` is low while `sleeping` is low.
- R10: A write to ctl stores all 8 bits. Writes to pflag and pen keep only bit 6, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tmr | input | 1 | Timer overflow event pulse |
| ev_ext | input | 1 | External pin event pulse |
| ev_chg | input | 1 | Port change event pulse |
| ev_adc | input | 1 | Converter complete event pulse |
| wr_ctl | input | 1 | Write strobe for the control register |
| wr_pflag | input | 1 | Write strobe for the peripheral flag register |
| wr_pen | input | 1 | Write strobe for the peripheral enable register |
| wr_data | input | 8 | Write data |
| inst_end | input | 1 | Instruction boundary marker |
| retfie | input | 1 | Return-from-interrupt strobe |
| sleeping | input | 1 | Core is in sleep mode |
| ctl_q | output | 8 | Control register contents |
| pflag_q | output | 8 | Peripheral flag register contents |
| pen_q | output | 8 | Peripheral enable register contents |
| irq_req | output | 1 | Synchronized interrupt request |
| vec_load | output | 1 | One-cycle vector-load strobe |
| vec_pc | output | 13 | Vector address, valid with vec_load |
| wake | output | 1 | Wake-up request |

## Verification
Flags are due one edge after their event and wake follows them with no added delay. A take is due at the first boundary edge at least three edges after the event, and the global enable drops on that same edge. A re-entry after the return strobe is due three edges after it. The bench drives inputs and samples outputs 1 ns after each rising edge and numbers every edge. The expected take edge is computed from that edge count and the boundary pattern, and the strobe must appear there and nowhere else in the scan window.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int DATA_W    = 8;
    localparam int B_GIE     = 7;
    localparam int B_PEIE    = 6;
    localparam int B_CHG_EN  = 3;
    localparam int N_CORE    = 3;
    localparam int B_ADC     = 6;

    typedef enum logic [1:0] {
        S_RUN = 2'd0,
        S_VEC = 2'd1,
        S_ISR = 2'd2
    } fsm_state_t;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CORE-1:0] hw_ev,
    input  logic              ev_adc,
    input  logic              wr_ctl,
    input  logic              wr_pflag,
    input  logic              wr_pen,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    input  logic              retfie,
    output logic [DATA_W-1:0] ctl_q,
    output logic [DATA_W-1:0] pflag_q,
    output logic [DATA_W-1:0] pen_q,
    output logic              src_hit,
    output logic              pend
);
    localparam int EN_W = B_GIE - B_CHG_EN;

    logic              gie_q;
    logic [EN_W-1:0]   en_q;
    logic [N_CORE-1:0] flg_q;
    logic              adc_f_q;
    logic              adc_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      gie_q <= 1'b0;
        else if (take)   gie_q <= 1'b0;
        else if (retfie) gie_q <= 1'b1;
        else if (wr_ctl) gie_q <= wr_data[B_GIE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_ctl) en_q <= wr_data[B_GIE-1:B_CHG_EN];
    end

    // Hardware set has priority over a software write to the same flag.
    for (genvar g = 0; g < N_CORE; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)      flg_q[g] <= 1'b0;
            else if (hw_ev[g]) flg_q[g] <= 1'b1;
            else if (wr_ctl) flg_q[g] <= wr_data[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        adc_f_q <= 1'b0;
        else if (ev_adc)   adc_f_q <= 1'b1;
        else if (wr_pflag) adc_f_q <= wr_data[B_ADC];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      adc_en_q <= 1'b0;
        else if (wr_pen) adc_en_q <= wr_data[B_ADC];
    end

    always_comb begin
        ctl_q          = {gie_q, en_q, flg_q};
        pflag_q        = '0;
        pflag_q[B_ADC] = adc_f_q;
        pen_q          = '0;
        pen_q[B_ADC]   = adc_en_q;
        src_hit        = (|(en_q[N_CORE-1:0] & flg_q))
                       | (en_q[B_PEIE-B_CHG_EN] & adc_en_q & adc_f_q);
        pend           = gie_q & src_hit;
    end

    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ev[N_CORE-1] |=> ctl_q[N_CORE-1]);
    p_hw_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_adc && wr_pflag) |=> pflag_q[B_ADC]);
    p_gie_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ctl_q[B_GIE]);
    p_retfie_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (retfie && !take) |=> ctl_q[B_GIE]);
endmodule

// File: rtl/irq_ctl_sync.sv
module irq_ctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sh[0] <= 1'b0;
                else        sh[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sh[s] <= 1'b0;
                else        sh[s] <= sh[s-1];
            end
        end
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/irq_ctl_fsm.sv
module irq_ctl_fsm
    import irq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    input  logic gie,
    input  logic inst_end,
    input  logic retfie,
    output logic take,
    output logic vec_load
);
    fsm_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        take    = (state_q != S_VEC) && inst_end && req_sync && gie;
        state_d = state_q;
        unique case (state_q)
            S_RUN:   if (take) state_d = S_VEC;
            S_VEC:   state_d = S_ISR;
            S_ISR:   if (take) state_d = S_VEC;
                     else if (retfie) state_d = S_RUN;
            default: state_d = S_RUN;
        endcase
    end

    always_comb begin
        vec_load = (state_q == S_VEC);
    end

    p_vec_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |=> !vec_load);
endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
    import irq_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PC_W        = 13,
    parameter int VEC_ADDR    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tmr,
    input  logic              ev_ext,
    input  logic              ev_chg,
    input  logic              ev_adc,
    input  logic              wr_ctl,
    input  logic              wr_pflag,
    input  logic              wr_pen,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inst_end,
    input  logic              retfie,
    input  logic              sleeping,
    output logic [DATA_W-1:0] ctl_q,
    output logic [DATA_W-1:0] pflag_q,
    output logic [DATA_W-1:0] pen_q,
    output logic              irq_req,
    output logic              vec_load,
    output logic [PC_W-1:0]   vec_pc,
    output logic              wake
);
    localparam logic [PC_W-1:0] VEC_PC = PC_W'(VEC_ADDR);

    logic take;
    logic src_hit;
    logic pend;

    irq_ctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_ev    ({ev_tmr, ev_ext, ev_chg}),
        .ev_adc   (ev_adc),
        .wr_ctl   (wr_ctl),
        .wr_pflag (wr_pflag),
        .wr_pen   (wr_pen),
        .wr_data  (wr_data),
        .take     (take),
        .retfie   (retfie),
        .ctl_q    (ctl_q),
        .pflag_q  (pflag_q),
        .pen_q    (pen_q),
        .src_hit  (src_hit),
        .pend     (pend)
    );

    irq_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pend),
        .q     (irq_req)
    );

    irq_ctl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_sync (irq_req),
        .gie      (ctl_q[B_GIE]),
        .inst_end (inst_end),
        .retfie   (retfie),
        .take     (take),
        .vec_load (vec_load)
    );

    assign vec_pc = vec_load ? VEC_PC : '0;
    assign wake   = sleeping & src_hit;

    p_vec_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> $past(irq_req));
    p_gie_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> $past(ctl_q[B_GIE]));
    p_vec_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> (vec_pc == VEC_PC));
endmodule

// File: tb/irq_ctl_unit_test.sv
`timescale 1ns/1ps
module irq_ctl_unit_test;
    logic clk = 0;
    logic rst_n = 0;
    logic ev_tmr = 0, ev_ext = 0, ev_chg = 0, ev_adc = 0;
    logic wr_ctl = 0, wr_pflag = 0, wr_pen = 0;
    logic [7:0] wr_data = 0;
    logic inst_end = 1, retfie = 0, sleeping = 0;
    logic [7:0] ctl_q, pflag_q, pen_q;
    logic irq_req, vec_load, wake;
    logic [12:0] vec_pc;

    int n_chk = 0, n_fail = 0;
    int edge_n = 0;
    int bmode = 0;

    always #2.5 clk = ~clk;

    irq_ctl_unit uut (
        .clk(clk), .rst_n(rst_n), .ev_tmr(ev_tmr), .ev_ext(ev_ext),
        .ev_chg(ev_chg), .ev_adc(ev_adc), .wr_ctl(wr_ctl),
        .wr_pflag(wr_pflag), .wr_pen(wr_pen), .wr_data(wr_data),
        .inst_end(inst_end), .retfie(retfie), .sleeping(sleeping),
        .ctl_q(ctl_q), .pflag_q(pflag_q), .pen_q(pen_q),
        .irq_req(irq_req), .vec_load(vec_load), .vec_pc(vec_pc), .wake(wake)
    );

    function automatic logic bnd(int e);
        if (bmode == 0) return 1'b1;
        if (bmode == 1) return (e % 2) == 0;
        return (e % 2) == 1;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        edge_n++;
        inst_end = bnd(edge_n);
        @(posedge clk);
        #1;
        ev_tmr = 0; ev_ext = 0; ev_chg = 0; ev_adc = 0;
        wr_ctl = 0; wr_pflag = 0; wr_pen = 0; retfie = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic fire(input int s);
        ev_tmr = (s == 0); ev_ext = (s == 1); ev_chg = (s == 2); ev_adc = (s == 3);
    endtask

    function automatic logic flag_of(input int s);
        if (s == 3) return pflag_q[6];
        return ctl_q[2 - s];
    endfunction

    // scan up to 8 edges; return edge number of first vec_load and count
    task automatic scan(output int first, output int cnt);
        first = -1; cnt = 0;
        for (int i = 0; i < 8; i++) begin
            tick();
            if (vec_load) begin
                cnt++;
                if (first < 0) begin
                    first = edge_n;
                    chk(vec_pc == 13'h4, "R6 vec_pc", vec_pc, 4);
                    chk(ctl_q[7] == 0, "R6 gie cleared", ctl_q[7], 0);
                end
            end
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int first, cnt, n_ev, exp_e;
        do_reset();
        // R1 reset state
        chk(ctl_q == 0 && pflag_q == 0 && pen_q == 0, "R1 regs", ctl_q, 0);
        chk(!irq_req && !vec_load && !wake, "R1 outputs", {irq_req, vec_load, wake}, 0);

        // R10 register writes
        wr_ctl = 1; wr_data = 8'h78; tick();
        chk(ctl_q == 8'h78, "R10 ctl write", ctl_q, 8'h78);
        wr_pflag = 1; wr_data = 8'hFF; tick();
        chk(pflag_q == 8'h40, "R10 pflag write", pflag_q, 8'h40);
        wr_pen = 1; wr_data = 8'hBF; tick();
        chk(pen_q == 8'h00, "R10 pen write", pen_q, 0);

        // R2 R4 R5 R6 R7 sweep over sources, enables and boundary patterns
        for (int m = 0; m < 3; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int c = 0; c < 8; c++) begin
                    logic g, en, pe, exp_take;
                    bmode = m;
                    g = c[0]; en = c[1]; pe = c[2];
                    do_reset();
                    wr_ctl = 1;
                    wr_data = {g, pe, en && s == 0, en && s == 1, en && s == 2, 3'b000};
                    tick();
                    wr_pen = 1; wr_data = {1'b0, en && s == 3, 6'b0}; tick();
                    fire(s); tick();
                    n_ev = edge_n;
                    chk(flag_of(s) == 1, "R2 flag set", flag_of(s), 1);
                    exp_take = g && en && (s != 3 || pe);
                    scan(first, cnt);
                    if (exp_take) begin
                        exp_e = n_ev + 3;
                        while (!bnd(exp_e)) exp_e++;
                        chk(first == exp_e && cnt == 1, "R7 take edge", first - n_ev, exp_e - n_ev);
                    end else if (!g) begin
                        chk(cnt == 0, "R4 blocked by gie", cnt, 0);
                    end else begin
                        chk(cnt == 0, "R5 blocked by enable", cnt, 0);
                    end
                end
            end
        end
        bmode = 0;

        // R3 hardware set wins over software clear
        do_reset();
        ev_ext = 1; tick();
        ev_tmr = 1; wr_ctl = 1; wr_data = 8'h00; tick();
        chk(ctl_q == 8'h04, "R3 hw wins ctl", ctl_q, 8'h04);
        ev_adc = 1; wr_pflag = 1; wr_data = 8'h00; tick();
        chk(pflag_q == 8'h40, "R3 hw wins pflag", pflag_q, 8'h40);

        // R8 re-entry with flag left set
        do_reset();
        wr_ctl = 1; wr_data = 8'hA0; tick();
        fire(0); tick();
        scan(first, cnt);
        chk(cnt == 1, "R8 first take", cnt, 1);
        retfie = 1; tick();
        n_ev = edge_n;
        chk(ctl_q[7] == 1, "R8 retfie sets gie", ctl_q[7], 1);
        scan(first, cnt);
        chk(first == n_ev + 3, "R8 re-entry edge", first - n_ev, 3);
        // clear flag before return: no re-entry
        wr_ctl = 1; wr_data = 8'h20; tick();
        retfie = 1; tick();
        scan(first, cnt);
        chk(cnt == 0, "R8 no re-entry", cnt, 0);

        // R9 wake while sleeping, gie clear
        do_reset();
        sleeping = 1;
        wr_ctl = 1; wr_data = 8'h20; tick();
        chk(wake == 0, "R9 no flag no wake", wake, 0);
        fire(0); tick();
        chk(wake == 1, "R9 timer wake", wake, 1);
        sleeping = 0; #0.1;
        chk(wake == 0, "R9 awake low", wake, 0);
        do_reset();
        sleeping = 1;
        wr_pen = 1; wr_data = 8'h40; tick();
        fire(3); tick();
        chk(wake == 0, "R9 adc without group", wake, 0);
        wr_ctl = 1; wr_data = 8'h40; tick();
        chk(wake == 1, "R9 adc with group", wake, 1);
        sleeping = 0;

        summary();
    end
endmodule